// File: doc/BRIEF.md
# Auxiliary T4 Transceiver Link Supervisor

This block sits inside an auto-negotiating Ethernet PHY and manages the hand-over of the link to an external 100BASE-T4 transceiver. When negotiation settles on T4 as the best shared technology, the block pulls an active-low enable toward the external transceiver. It then waits for that transceiver's link-good signal, timing the wait against a millisecond tick. If the link does not come up in time, or if it drops after coming up, the block requests a fresh auto-negotiation with a one-cycle restart pulse.

With negotiation switched off, the external enable is held asserted. The manual speed bit then decides what happens. At 100 Mb/s, link-good reports the link and shuts down the local TX analog path. At 10 Mb/s, link-good is ignored. During parallel detection, link-good alone tells whether a T4 link is ready.

The link-good input is asynchronous and passes through a two-stage synchronizer. The negotiation arbitration, the management registers and the serial management framing all live outside this block.

Top module: `aux_link_supervisor`

## Requirements
- R1: After reset, with negotiation enabled and no T4 result present, `t4_en_n` is 1 and `an_restart`, `link_up` and `tx_analog_off` are 0.
- R2: With `an_enable`=1, `t4_en_n` drops to 0 one clock edge after `an_t4_chosen` goes to 1. It stays at 1 while `an_t4_chosen` is 0, which covers negotiation in progress and any other technology.
- R3: While `an_enable`=0, `t4_en_n` is 0 in every cycle and `an_restart` never pulses.
- R4: While the T4 enable is asserted under negotiation, a rise of `link_good_raw` makes `link_up` go to 1 three clock edges later, with no restart.
- R5: After the enable is asserted, the wait counter starts from zero and counts `tick_1ms` pulses. After TIMEOUT_MS-1 ticks (default 1000) no restart has occurred. One edge after the edge that samples tick number TIMEOUT_MS, `an_restart` is 1 and `t4_en_n` is back at 1.
- R6: Once the link is up under negotiation, a fall of `link_good_raw` produces `an_restart`=1 three clock edges later.
- R7: With `an_enable`=1, no T4 result and `pd_request`=1, `link_up` follows `link_good_raw` two clock edges later while `t4_en_n` stays 1.
- R8: With `an_enable`=0 and `speed_100`=1 (100 Mb/s), `link_up` and `tx_analog_off` both follow `link_good_raw` two clock edges later.
- R9: With `an_enable`=0 and `speed_100`=0, `link_good_raw` has no effect: `link_up` and `tx_analog_off` stay 0.
- R10: `an_restart` is high for exactly one cycle per restart, and the block then returns to idle with `t4_en_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_t4_chosen | input | 1 | Negotiation result: T4 is the chosen common technology |
| speed_100 | input | 1 | Manual speed select, 1 = 100 Mb/s |
| pd_request | input | 1 | Parallel detection in progress |
| link_good_raw | input | 1 | Asynchronous link-good from the external transceiver |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| t4_en_n | output | 1 | Active-low enable to the external transceiver |
| an_restart | output | 1 | One-cycle auto-negotiation restart request |
| tx_analog_off | output | 1 | Disable for the local TX analog path |
| link_up | output | 1 | Link status flag |

## Verification
`t4_en_n` follows a negotiation result one edge later. The combinational forced-mode and parallel-detection outputs follow `link_good_raw` after the two synchronizer edges. State-based results (link up under negotiation, restart on link loss) need a third edge for the state register. A timeout restart appears one edge after the edge that samples the final tick. The bench changes inputs just after a falling edge and samples just after later falling edges. It counts the rising edges it lets pass, and it also checks one edge early, so that both an early result and a late result are reported.

// File: rtl/aux_link_pkg.sv
package aux_link_pkg;

  typedef enum logic [1:0] {
    SUP_IDLE    = 2'd0,
    SUP_WAIT    = 2'd1,
    SUP_UP      = 2'd2,
    SUP_RESTART = 2'd3
  } sup_state_t;

  // Saturating millisecond counter step.
  function automatic int unsigned wait_count_next(int unsigned cur, logic tick,
                                                  int unsigned limit);
    if (tick && cur < limit) return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/wait_timer.sv
module wait_timer
  import aux_link_pkg::*;
#(
  parameter int LIMIT_MS = 1000,
  localparam int CW = $clog2(LIMIT_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else cnt_q <= CW'(wait_count_next(int'(cnt_q), tick, LIMIT_MS));
  end

  assign expired = (int'(cnt_q) == LIMIT_MS);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= LIMIT_MS);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q) && cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/supervisor_fsm.sv
module supervisor_fsm
  import aux_link_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic an_enable,
  input  logic an_t4_chosen,
  input  logic speed_100,
  input  logic pd_request,
  input  logic link_ok,
  input  logic timer_hit,
  output logic timer_clear,
  output logic t4_en_n,
  output logic an_restart,
  output logic tx_analog_off,
  output logic link_up
);
  sup_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!an_enable) state_d = SUP_IDLE;
    else begin
      unique case (state_q)
        SUP_IDLE:    if (an_t4_chosen) state_d = SUP_WAIT;
        SUP_WAIT:    if (!an_t4_chosen)  state_d = SUP_IDLE;
                     else if (link_ok)   state_d = SUP_UP;
                     else if (timer_hit) state_d = SUP_RESTART;
        SUP_UP:      if (!an_t4_chosen)  state_d = SUP_IDLE;
                     else if (!link_ok)  state_d = SUP_RESTART;
        SUP_RESTART: state_d = SUP_IDLE;
        default:     state_d = SUP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SUP_IDLE;
    else        state_q <= state_d;
  end

  logic t4_active;
  assign t4_active   = (state_q == SUP_WAIT) || (state_q == SUP_UP);
  assign timer_clear = (state_q != SUP_WAIT);
  assign t4_en_n     = an_enable ? !t4_active : 1'b0;
  assign an_restart  = an_enable && (state_q == SUP_RESTART);
  assign tx_analog_off = !an_enable && speed_100 && link_ok;
  assign link_up = an_enable
                 ? ((state_q == SUP_UP) || (state_q == SUP_IDLE && pd_request && link_ok))
                 : (speed_100 && link_ok);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart);

  assert_restart_after_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |-> $past(!t4_en_n));

  assert_up_needs_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_UP) |-> $past(link_ok));

  assert_no_restart_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !an_enable |=> (state_q == SUP_IDLE));
endmodule

// File: rtl/aux_link_supervisor.sv
module aux_link_supervisor #(
  parameter int TIMEOUT_MS  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic an_enable,
  input  logic an_t4_chosen,
  input  logic speed_100,
  input  logic pd_request,
  input  logic link_good_raw,
  input  logic tick_1ms,
  output logic t4_en_n,
  output logic an_restart,
  output logic tx_analog_off,
  output logic link_up
);
  logic link_ok, timer_hit, timer_clear;

  link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(link_good_raw), .sync_out(link_ok));

  wait_timer #(.LIMIT_MS(TIMEOUT_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear), .tick(tick_1ms),
    .expired(timer_hit));

  supervisor_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_t4_chosen(an_t4_chosen),
    .speed_100(speed_100), .pd_request(pd_request), .link_ok(link_ok),
    .timer_hit(timer_hit), .timer_clear(timer_clear), .t4_en_n(t4_en_n),
    .an_restart(an_restart), .tx_analog_off(tx_analog_off), .link_up(link_up));
endmodule

// File: tb/aux_link_supervisor_test.sv
module aux_link_supervisor_test;
  localparam int LIMIT = 1000;

  logic clk = 1'b0;
  logic rst_n, an_enable, an_t4_chosen, speed_100, pd_request, link_good_raw, tick_1ms;
  logic t4_en_n, an_restart, tx_analog_off, link_up;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  aux_link_supervisor uut (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_t4_chosen(an_t4_chosen),
    .speed_100(speed_100), .pd_request(pd_request), .link_good_raw(link_good_raw),
    .tick_1ms(tick_1ms), .t4_en_n(t4_en_n), .an_restart(an_restart),
    .tx_analog_off(tx_analog_off), .link_up(link_up));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic quiesce();
    an_t4_chosen = 0; pd_request = 0; link_good_raw = 0; tick_1ms = 0;
    an_enable = 1; speed_100 = 0;
    step(4);
  endtask

  task automatic test_reset_r1();
    rst_n = 0; an_enable = 1; an_t4_chosen = 0; speed_100 = 0;
    pd_request = 0; link_good_raw = 0; tick_1ms = 0;
    step(3); rst_n = 1; step(1);
    check("R1 t4_en_n", t4_en_n, 1'b1);
    check("R1 an_restart", an_restart, 1'b0);
    check("R1 link_up", link_up, 1'b0);
    check("R1 tx_analog_off", tx_analog_off, 1'b0);
  endtask

  task automatic test_enable_r2();
    quiesce();
    step(3);
    check("R2 held high without result", t4_en_n, 1'b1);
    an_t4_chosen = 1;
    check("R2 not before edge", t4_en_n, 1'b1);
    step(1);
    check("R2 low one edge after result", t4_en_n, 1'b0);
    an_t4_chosen = 0; step(1);
    check("R2 high again when result drops", t4_en_n, 1'b1);
  endtask

  task automatic test_link_up_r4_r6();
    quiesce();
    an_t4_chosen = 1; step(1);
    link_good_raw = 1; step(2);
    check("R4 link_up not before third edge", link_up, 1'b0);
    step(1);
    check("R4 link_up after three edges", link_up, 1'b1);
    check("R4 no restart", an_restart, 1'b0);
    link_good_raw = 0; step(2);
    check("R6 no restart before third edge", an_restart, 1'b0);
    step(1);
    check("R6 restart after link loss", an_restart, 1'b1);
    an_t4_chosen = 0; step(1);
    check("R10 pulse ends", an_restart, 1'b0);
    check("R10 idle enable high", t4_en_n, 1'b1);
  endtask

  task automatic test_timeout_r5();
    logic early = 1'b0;
    quiesce();
    an_t4_chosen = 1; step(1);
    check("R5 enable asserted", t4_en_n, 1'b0);
    for (int i = 0; i < LIMIT - 1; i++) begin
      tick_1ms = 1; step(1); tick_1ms = 0;
      if (an_restart) early = 1'b1;
      step(1);
      if (an_restart) early = 1'b1;
    end
    check("R5 no restart before limit", early, 1'b0);
    tick_1ms = 1; step(1); tick_1ms = 0;
    check("R5 not on final tick edge", an_restart, 1'b0);
    step(1);
    check("R5 restart after limit", an_restart, 1'b1);
    check("R10 enable high during restart", t4_en_n, 1'b1);
    an_t4_chosen = 0; step(1);
    check("R10 single cycle pulse", an_restart, 1'b0);
  endtask

  task automatic test_reload_r5();
    quiesce();
    an_t4_chosen = 1; step(1);
    for (int i = 0; i < 600; i++) begin tick_1ms = 1; step(1); tick_1ms = 0; step(1); end
    an_t4_chosen = 0; step(2); an_t4_chosen = 1; step(1);
    for (int i = 0; i < 600; i++) begin tick_1ms = 1; step(1); tick_1ms = 0; step(1); end
    check("R5 counter reloads on re-enable", an_restart, 1'b0);
    check("R5 still waiting", t4_en_n, 1'b0);
    an_t4_chosen = 0; step(1);
  endtask

  task automatic test_pd_r7();
    quiesce();
    pd_request = 1; link_good_raw = 1; step(1);
    check("R7 not after one edge", link_up, 1'b0);
    step(1);
    check("R7 link ready", link_up, 1'b1);
    check("R7 enable stays high", t4_en_n, 1'b1);
  endtask

  task automatic test_forced_r3_r8_r9();
    logic pulsed = 1'b0;
    quiesce();
    an_enable = 0; an_t4_chosen = 1; step(1);
    check("R3 enable low when negotiation off", t4_en_n, 1'b0);
    speed_100 = 1; link_good_raw = 1; step(1);
    check("R8 not after one edge", link_up, 1'b0);
    step(1);
    check("R8 link valid", link_up, 1'b1);
    check("R8 tx analog off", tx_analog_off, 1'b1);
    speed_100 = 0;
    for (int i = 0; i < 6; i++) begin
      link_good_raw = ~link_good_raw; step(1);
      if (link_up || tx_analog_off) pulsed = 1'b1;
    end
    check("R9 link-good ignored at 10M", pulsed, 1'b0);
    pulsed = 1'b0;
    for (int i = 0; i < 1100; i++) begin
      tick_1ms = (i % 2 == 0); step(1);
      if (an_restart || t4_en_n) pulsed = 1'b1;
    end
    tick_1ms = 0;
    check("R3 no restart and enable stays low", pulsed, 1'b0);
  endtask

  initial begin
    test_reset_r1();
    test_enable_r2();
    test_link_up_r4_r6();
    test_timeout_r5();
    test_reload_r5();
    test_pd_r7();
    test_forced_r3_r8_r9();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule